// File: doc/BRIEF.md
# Unlock-Sequence Command Decoder for Parallel Flash

This block sits on the device side of a parallel flash. It watches the write cycles presented on the address and data pins and decides whether they form one of the fixed unlock sequences. Only a correct sequence lets a program or erase through. Protection is permanent and has no bypass. Every data-altering operation must be preceded by two key cycles: AAH written to address 5555H, then 55H written to 2AAAH. The third cycle is a command byte written to 5555H.

After the command A0H, the next accepted write is the program cycle. The block pulses `prog_en` and reports that cycle's address and data. After the command 80H, a second key pair is needed, followed by an erase-type code. The block then pulses `erase_en` with the selected erase kind. The command 98H enters a query mode, which lasts until an exit byte F0H is written. A write that does not fit the expected sequence drops the decoder back to idle.

A write cycle is counted only when the strobe stays asserted for a minimum number of clocks. Chip-enable must be low, output-enable high and write-enable low for every one of those clocks. A strobe held longer still counts as one write. The program, erase and query outputs feed the array controller, which is outside this block.

Top module: `sdp_cmd_decoder`

## Requirements
- R1: The writes AAH@5555H, 55H@2AAAH and A0H@5555H, followed by one more accepted write at any address, give a single-clock `prog_en` pulse. The pulse appears in the clock after that fourth write is accepted, with `cmd_addr`/`cmd_data` equal to the fourth write. The decoder then returns to idle.
- R2: The writes AAH@5555H, 55H@2AAAH, 80H@5555H, AAH@5555H and 55H@2AAAH, followed by an erase code, give a single-clock `erase_en` pulse. The codes are 30H at any address (sector, `erase_sel`=01), 50H at any address (block, `erase_sel`=10) and 10H at 5555H only (chip, `erase_sel`=11). `cmd_addr`/`cmd_data` carry the code cycle. `erase_sel` is 00 whenever `erase_en` is low.
- R3: Any write that does not match the next expected cycle returns the decoder to idle with no enable pulse. This includes a wrong address, a wrong byte, an unknown erase code, 10H away from 5555H, and a command byte written without the key cycles. A later operation needs a complete fresh sequence.
- R4: The writes AAH@5555H, 55H@2AAAH and 98H@5555H set `query_mode`. While it is set, every write other than F0H leaves it set and produces no enable pulse.
- R5: An accepted write of F0H at any address clears `query_mode` and returns to idle. This applies in every state except the state waiting for the program cycle, where F0H is taken as program data.
- R6: A strobe pulse is ignored, and the sequence state is kept, if during the pulse `ce_n` is high, `oe_n` is low or `we_n` is high.
- R7: A strobe pulse shorter than MIN_PULSE clocks (default 2) is ignored and leaves the sequence state unchanged.
- R8: A strobe held for more than MIN_PULSE clocks counts as exactly one write.
- R9: After reset, `prog_en`=0, `erase_en`=0, `erase_sel`=00, `query_mode`=0 and `read_mode`=1.
- R10: `read_mode` is 1 only when no sequence is in progress and query mode is off. It is 0 from the first key cycle until the sequence completes or aborts.
- R11: The unlock addresses are compared on the low 15 address bits only. The upper address bits do not matter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_strobe | input | 1 | Raw write strobe, qualified by width |
| addr | input | ADDR_W | Write address |
| data | input | 8 | Write data |
| ce_n | input | 1 | Chip-enable level, active low |
| oe_n | input | 1 | Output-enable level, active low |
| we_n | input | 1 | Write-enable level, active low |
| prog_en | output | 1 | One-clock program permission pulse |
| erase_en | output | 1 | One-clock erase permission pulse |
| erase_sel | output | 2 | Erase kind: 01 sector, 10 block, 11 chip |
| cmd_addr | output | ADDR_W | Address of the final qualifying cycle |
| cmd_data | output | 8 | Data of the final qualifying cycle |
| query_mode | output | 1 | Query mode active |
| read_mode | output | 1 | Idle and not in query mode |

## Verification
Some rules can be checked on every cycle. The program and erase pulses are mutually exclusive, and a program pulse never lasts a second clock. `erase_sel` agrees with `erase_en`. Nothing changes in a clock that follows a cycle with no accepted write, or one sampled with chip-enable high. Query mode and read mode are never set together. Whether a given address and data order opens the gate can only be shown by the bench scenarios, because it depends on the sequence and not on one cycle. These scenarios cover full program and erase sequences, aborts at different steps, and query entry and exit. They also place inhibited, glitched and over-long strobes inside otherwise valid sequences.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
    localparam int MATCH_W = 15;
    localparam logic [MATCH_W-1:0] KEY_ADDR_A = 15'h5555;
    localparam logic [MATCH_W-1:0] KEY_ADDR_B = 15'h2AAA;

    localparam logic [7:0] BYTE_KEY1   = 8'hAA;
    localparam logic [7:0] BYTE_KEY2   = 8'h55;
    localparam logic [7:0] BYTE_PROG   = 8'hA0;
    localparam logic [7:0] BYTE_ERASE  = 8'h80;
    localparam logic [7:0] BYTE_QUERY  = 8'h98;
    localparam logic [7:0] BYTE_EXIT   = 8'hF0;
    localparam logic [7:0] BYTE_CHIP   = 8'h10;
    localparam logic [7:0] BYTE_SECTOR = 8'h30;
    localparam logic [7:0] BYTE_BLOCK  = 8'h50;

    typedef enum logic [3:0] {
        BK_KEY1, BK_KEY2, BK_PROG, BK_ERASE, BK_QUERY,
        BK_EXIT, BK_CHIP, BK_SECTOR, BK_BLOCK, BK_OTHER
    } byte_kind_e;

    typedef enum logic [2:0] {
        S_IDLE, S_KEY1, S_KEY2, S_PROG, S_ER3, S_ER4, S_ER5
    } seq_state_e;

    typedef enum logic [1:0] {
        ER_NONE   = 2'b00,
        ER_SECTOR = 2'b01,
        ER_BLOCK  = 2'b10,
        ER_CHIP   = 2'b11
    } erase_sel_e;
endpackage

// File: rtl/sdp_strobe_qual.sv
module sdp_strobe_qual #(
    parameter int MIN_PULSE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic accept
);
    localparam int CNT_W = $clog2(MIN_PULSE + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } qual_t;

    qual_t q_q, q_d;
    logic  allowed;

    always_comb begin
        allowed = strobe && !ce_n && oe_n && !we_n;
        accept  = allowed && (q_q.cnt == CNT_W'(MIN_PULSE - 1));
        q_d     = q_q;
        if (!allowed) begin
            q_d.cnt = '0;
        end else if (q_q.cnt != CNT_W'(MIN_PULSE)) begin
            q_d.cnt = q_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end
endmodule

// File: rtl/sdp_cycle_match.sv
module sdp_cycle_match
    import sdp_pkg::*;
(
    input  logic [MATCH_W-1:0] addr_lo,
    input  logic [7:0]         data,
    output logic               at_a,
    output logic               at_b,
    output byte_kind_e         kind
);
    always_comb begin
        at_a = (addr_lo == KEY_ADDR_A);
        at_b = (addr_lo == KEY_ADDR_B);
        case (data)
            BYTE_KEY1:   kind = BK_KEY1;
            BYTE_KEY2:   kind = BK_KEY2;
            BYTE_PROG:   kind = BK_PROG;
            BYTE_ERASE:  kind = BK_ERASE;
            BYTE_QUERY:  kind = BK_QUERY;
            BYTE_EXIT:   kind = BK_EXIT;
            BYTE_CHIP:   kind = BK_CHIP;
            BYTE_SECTOR: kind = BK_SECTOR;
            BYTE_BLOCK:  kind = BK_BLOCK;
            default:     kind = BK_OTHER;
        endcase
    end
endmodule

// File: rtl/sdp_seq_fsm.sv
module sdp_seq_fsm
    import sdp_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    input  logic              at_a,
    input  logic              at_b,
    input  byte_kind_e        kind,
    output logic              prog_en,
    output logic              erase_en,
    output logic [1:0]        erase_sel,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [7:0]        cmd_data,
    output logic              query_mode,
    output logic              read_mode
);
    typedef struct packed {
        seq_state_e        state;
        logic              query;
        logic              prog;
        logic              erase;
        erase_sel_e        sel;
        logic [ADDR_W-1:0] caddr;
        logic [7:0]        cdata;
    } fsm_t;

    fsm_t q_q, q_d;

    always_comb begin
        q_d       = q_q;
        q_d.prog  = 1'b0;
        q_d.erase = 1'b0;
        q_d.sel   = ER_NONE;
        if (acc) begin
            if (kind == BK_EXIT && q_q.state != S_PROG) begin
                q_d.state = S_IDLE;
                q_d.query = 1'b0;
            end else if (!q_q.query) begin
                q_d.state = S_IDLE;
                case (q_q.state)
                    S_IDLE: if (at_a && kind == BK_KEY1) q_d.state = S_KEY1;
                    S_KEY1: if (at_b && kind == BK_KEY2) q_d.state = S_KEY2;
                    S_KEY2: begin
                        if (at_a) begin
                            case (kind)
                                BK_PROG:  q_d.state = S_PROG;
                                BK_ERASE: q_d.state = S_ER3;
                                BK_QUERY: q_d.query = 1'b1;
                                default:  q_d.state = S_IDLE;
                            endcase
                        end
                    end
                    S_PROG: begin
                        q_d.prog  = 1'b1;
                        q_d.caddr = addr;
                        q_d.cdata = data;
                    end
                    S_ER3: if (at_a && kind == BK_KEY1) q_d.state = S_ER4;
                    S_ER4: if (at_b && kind == BK_KEY2) q_d.state = S_ER5;
                    S_ER5: begin
                        case (kind)
                            BK_SECTOR: q_d.sel = ER_SECTOR;
                            BK_BLOCK:  q_d.sel = ER_BLOCK;
                            BK_CHIP:   q_d.sel = at_a ? ER_CHIP : ER_NONE;
                            default:   q_d.sel = ER_NONE;
                        endcase
                        if (q_d.sel != ER_NONE) begin
                            q_d.erase = 1'b1;
                            q_d.caddr = addr;
                            q_d.cdata = data;
                        end
                    end
                    default: q_d.state = S_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '{state: S_IDLE, query: 1'b0, prog: 1'b0, erase: 1'b0,
                     sel: ER_NONE, caddr: '0, cdata: '0};
        end else begin
            q_q <= q_d;
        end
    end

    assign prog_en    = q_q.prog;
    assign erase_en   = q_q.erase;
    assign erase_sel  = q_q.sel;
    assign cmd_addr   = q_q.caddr;
    assign cmd_data   = q_q.cdata;
    assign query_mode = q_q.query;
    assign read_mode  = (q_q.state == S_IDLE) && !q_q.query;
endmodule

// File: rtl/sdp_cmd_decoder.sv
module sdp_cmd_decoder
    import sdp_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int MIN_PULSE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_strobe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    output logic              prog_en,
    output logic              erase_en,
    output logic [1:0]        erase_sel,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [7:0]        cmd_data,
    output logic              query_mode,
    output logic              read_mode
);
    logic       wr_acc;
    logic       hit_a;
    logic       hit_b;
    byte_kind_e bkind;

    sdp_strobe_qual #(.MIN_PULSE(MIN_PULSE)) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (wr_strobe),
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .we_n   (we_n),
        .accept (wr_acc)
    );

    sdp_cycle_match u_match (
        .addr_lo (addr[MATCH_W-1:0]),
        .data    (data),
        .at_a    (hit_a),
        .at_b    (hit_b),
        .kind    (bkind)
    );

    sdp_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc        (wr_acc),
        .addr       (addr),
        .data       (data),
        .at_a       (hit_a),
        .at_b       (hit_b),
        .kind       (bkind),
        .prog_en    (prog_en),
        .erase_en   (erase_en),
        .erase_sel  (erase_sel),
        .cmd_addr   (cmd_addr),
        .cmd_data   (cmd_data),
        .query_mode (query_mode),
        .read_mode  (read_mode)
    );
endmodule

// File: rtl/sdp_cmd_decoder_chk.sv
module sdp_cmd_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       acc,
    input logic       ce_n,
    input logic       prog_en,
    input logic       erase_en,
    input logic [1:0] erase_sel,
    input logic       query_mode,
    input logic       read_mode
);
    assert_single_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_en, erase_en}));

    assert_prog_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |=> !prog_en);

    assert_erase_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en == (erase_sel != 2'b00));

    assert_chip_inhibit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ce_n) |-> (!prog_en && !erase_en && $stable(query_mode) && $stable(read_mode)));

    assert_no_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(acc) |-> (!prog_en && !erase_en && $stable(query_mode) && $stable(read_mode)));

    assert_query_not_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        query_mode |-> !read_mode);
endmodule

bind sdp_cmd_decoder sdp_cmd_decoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc        (wr_acc),
    .ce_n       (ce_n),
    .prog_en    (prog_en),
    .erase_en   (erase_en),
    .erase_sel  (erase_sel),
    .query_mode (query_mode),
    .read_mode  (read_mode)
);

// File: tb/sdp_cmd_decoder_test.sv
`timescale 1ns/1ps
module sdp_cmd_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_strobe = 1'b0;
    logic [19:0] addr = '0;
    logic [7:0]  data = '0;
    logic        ce_n = 1'b0;
    logic        oe_n = 1'b1;
    logic        we_n = 1'b0;
    logic        prog_en, erase_en, query_mode, read_mode;
    logic [1:0]  erase_sel;
    logic [19:0] cmd_addr;
    logic [7:0]  cmd_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic        prog;
        logic [1:0]  sel;
        logic [19:0] a;
        logic [7:0]  d;
    } ev_t;
    ev_t expq[$];

    always #2 clk = ~clk;

    sdp_cmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .addr(addr), .data(data),
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .prog_en(prog_en), .erase_en(erase_en),
        .erase_sel(erase_sel), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .query_mode(query_mode), .read_mode(read_mode)
    );

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic p, input logic [1:0] s, input logic [19:0] a, input logic [7:0] d);
        ev_t e;
        e.prog = p; e.sel = s; e.a = a; e.d = d;
        expq.push_back(e);
    endtask

    task automatic wrx(input logic [19:0] a, input logic [7:0] d, input int w,
                       input logic c, input logic o, input logic e);
        @(negedge clk);
        addr = a; data = d; ce_n = c; oe_n = o; we_n = e; wr_strobe = 1'b1;
        repeat (w) @(negedge clk);
        wr_strobe = 1'b0; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [19:0] a, input logic [7:0] d);
        wrx(a, d, 2, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic unlock(input logic [7:0] cmd);
        wr(20'h05555, 8'hAA);
        wr(20'h02AAA, 8'h55);
        wr(20'h05555, cmd);
    endtask

    // monitor: pops expected events as the design pulses
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && (prog_en || erase_en)) begin
                checks++;
                if (expq.size() == 0) begin
                    failures++;
                    $display("FAIL R3 unexpected enable actual=%b%b%h expected=none",
                             prog_en, erase_en, erase_sel);
                end else begin
                    ev_t e;
                    e = expq.pop_front();
                    if ({prog_en, erase_sel, cmd_addr, cmd_data} !== {e.prog, e.sel, e.a, e.d}) begin
                        failures++;
                        $display("FAIL R1/R2 event actual=%h expected=%h",
                                 {prog_en, erase_sel, cmd_addr, cmd_data}, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 prog_en", prog_en, 0);
        chk("R9 erase_en", erase_en, 0);
        chk("R9 erase_sel", erase_sel, 0);
        chk("R9 query_mode", query_mode, 0);
        chk("R9 read_mode", read_mode, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 program with R10 read_mode tracking
        wr(20'h05555, 8'hAA);
        chk("R10 read_mode mid sequence", read_mode, 0);
        wr(20'h02AAA, 8'h55);
        wr(20'h05555, 8'hA0);
        push(1'b1, 2'b00, 20'h12345, 8'h3C);
        wr(20'h12345, 8'h3C);
        chk("R1 back to idle", read_mode, 1);

        // R2 erase variants
        unlock(8'h80); wr(20'h05555, 8'hAA); wr(20'h02AAA, 8'h55);
        push(1'b0, 2'b01, 20'h40000, 8'h30);
        wr(20'h40000, 8'h30);
        unlock(8'h80); wr(20'h05555, 8'hAA); wr(20'h02AAA, 8'h55);
        push(1'b0, 2'b10, 20'h07000, 8'h50);
        wr(20'h07000, 8'h50);
        unlock(8'h80); wr(20'h05555, 8'hAA); wr(20'h02AAA, 8'h55);
        push(1'b0, 2'b11, 20'h05555, 8'h10);
        wr(20'h05555, 8'h10);
        chk("R2 idle after erase", read_mode, 1);

        // R3 aborts: chip code off 5555H, unknown code, wrong key address, no-key command
        unlock(8'h80); wr(20'h05555, 8'hAA); wr(20'h02AAA, 8'h55);
        wr(20'h01234, 8'h10);
        chk("R3 abort chip wrong addr", read_mode, 1);
        unlock(8'h80); wr(20'h05555, 8'hAA); wr(20'h02AAA, 8'h55);
        wr(20'h01234, 8'h77);
        wr(20'h05555, 8'hAA);
        wr(20'h01234, 8'h55);
        chk("R3 abort wrong key addr", read_mode, 1);
        wr(20'h05555, 8'hA0);
        wr(20'h00100, 8'h11);
        chk("R3 command without keys", read_mode, 1);

        // R11 upper address bits ignored
        wr(20'hF5555, 8'hAA); wr(20'hA2AAA, 8'h55); wr(20'h85555, 8'hA0);
        push(1'b1, 2'b00, 20'hFFFFF, 8'h00);
        wr(20'hFFFFF, 8'h00);

        // R6 inhibited writes inside a sequence keep state
        wr(20'h05555, 8'hAA);
        wrx(20'h01111, 8'h99, 2, 1'b1, 1'b1, 1'b0);
        wrx(20'h01111, 8'h99, 2, 1'b0, 1'b0, 1'b0);
        wrx(20'h01111, 8'h99, 2, 1'b0, 1'b1, 1'b1);
        chk("R6 state kept", read_mode, 0);
        wr(20'h02AAA, 8'h55); wr(20'h05555, 8'hA0);
        push(1'b1, 2'b00, 20'h00042, 8'h5A);
        wr(20'h00042, 8'h5A);

        // R7 short glitch ignored; a short valid key does not count
        wr(20'h05555, 8'hAA);
        wrx(20'h01111, 8'h99, 1, 1'b0, 1'b1, 1'b0);
        wr(20'h02AAA, 8'h55); wr(20'h05555, 8'hA0);
        push(1'b1, 2'b00, 20'h00777, 8'hC3);
        wr(20'h00777, 8'hC3);
        wrx(20'h05555, 8'hAA, 1, 1'b0, 1'b1, 1'b0);
        chk("R7 short key ignored", read_mode, 1);

        // R8 long strobe counts once
        wrx(20'h05555, 8'hAA, 7, 1'b0, 1'b1, 1'b0);
        wr(20'h02AAA, 8'h55); wr(20'h05555, 8'hA0);
        push(1'b1, 2'b00, 20'h00888, 8'h81);
        wrx(20'h00888, 8'h81, 6, 1'b0, 1'b1, 1'b0);
        chk("R8 idle after long write", read_mode, 1);

        // R4 query mode entry and persistence
        unlock(8'h98);
        chk("R4 query set", query_mode, 1);
        chk("R4 read_mode off", read_mode, 0);
        unlock(8'hA0);
        wr(20'h00999, 8'h12);
        chk("R4 query held", query_mode, 1);

        // R5 exit
        wr(20'h03333, 8'hF0);
        chk("R5 query cleared", query_mode, 0);
        chk("R5 read_mode back", read_mode, 1);
        wr(20'h05555, 8'hAA); wr(20'h02AAA, 8'h55);
        wr(20'h04444, 8'hF0);
        chk("R5 exit mid sequence", read_mode, 1);
        wr(20'h05555, 8'hA0);
        wr(20'h00123, 8'h45);
        // R5 F0H as program data
        unlock(8'hA0);
        push(1'b1, 2'b00, 20'h00321, 8'hF0);
        wr(20'h00321, 8'hF0);

        repeat (4) @(negedge clk);
        chk("R1 R2 all expected events seen", expq.size(), 0);
        done = 1'b1;
        report();
        $finish;
    end
endmodule